// File: doc/BRIEF.md
# Center-Aligned Fractional-Duty PWM Generator

This block produces a symmetric, center-aligned PWM from an up-down counter and a compare value that has an integer part and a fractional part. The integer part sets the coarse switching points on the triangular carrier. The fractional part becomes a count of fine delay steps. Each edge of the coarse waveform is paired with its own fine-step offset, which an external delay line applies to place the edge inside a clock cycle.

The fraction can be scaled by a calibrated steps-per-clock value, with rounding. It can also be passed straight through as a raw step count. A select input chooses which edges carry the fine offset. In symmetric mode, both edges move in opposite directions, so the pulse widens or narrows evenly about the carrier's turnaround instead of only shifting in phase.

All settings are taken from the inputs only at the carrier's two turnaround points. Every pulse is therefore built from one consistent set of values.

Top module: `cpwm_top`

## Requirements
- R1: The counter runs 0,1,…,P,P-1,…,1,0,… where P is the active period, so one carrier cycle lasts 2·P clocks. A new period is adopted only when the count is 0.
- R2: The 32-bit compare word holds the integer compare in bits 31:16 and the fraction in bits 15:0. Only the integer part sets the coarse edge positions.
- R3: With conversion enabled, the fine-step count is (F·S + 128) >> 8, where F is bits 15:8 of the compare word and S is steps-per-clock.
- R4: With conversion disabled, the fine-step count equals bits 15:8 of the compare word.
- R5: The fine-step count is clamped to S-1, and it is 0 when S is 0.
- R6: With 0 < C < P, the output goes low one clock after the count equals C while counting up, and goes high one clock after the count equals C while counting down. This gives 2·C high clocks per carrier cycle.
- R7: An integer compare of 0 holds the output high. A compare greater than or equal to P holds it low. In both cases both fine offsets are 0.
- R8: The edge select codes are: 0 for no fine offset, 1 for the rising edge only, 2 for the falling edge only, and 3 for both edges. In codes 1 and 2, the other edge's offset is 0.
- R9: With code 3 and symmetric mode off, both offsets equal the fine-step count N.
- R10: With code 3, symmetric mode on and N > 0:
  - the falling offset is N;
  - the rising offset is S-N;
  - the coarse rising edge fires at count C+1 while counting down, giving 2·C+1 coarse high clocks.
  With N = 0, both offsets are 0 and the waveform is the same as in R6.
- R11: The compare value, the offsets and the mode settings are loaded only when the count is 0 or equal to P. Between those points the offset outputs do not change.
- R12: During reset, the output is low and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_word | input | 32 | Integer compare (31:16) and fraction (15:0) |
| period | input | 16 | Carrier peak count P |
| steps_per_clk | input | 8 | Calibrated fine steps in one clock |
| edge_sel | input | 2 | Which edges take a fine offset |
| sym_en | input | 1 | Move the two edges in opposite directions |
| conv_en | input | 1 | Scale the fraction by steps-per-clock |
| pwm_out | output | 1 | Coarse PWM level |
| rise_steps | output | 8 | Fine delay for the rising edge |
| fall_steps | output | 8 | Fine delay for the falling edge |

## Verification
The assertions assume that the period changes only by being re-sampled at count zero. They also assume that the counter never has to recover from a count above a freshly shrunk period. The stimulus meets both conditions: it drives every input on the falling clock edge and keeps the period at 20 or more. The clamp property assumes a steady steps-per-clock value within a cycle, and the bench changes that value only between carrier cycles. The integer compare is swept across 0, the in-range values and values at or above the period, so that every hold and edge branch is reached.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cpwm_tri_counter.sv
module cpwm_tri_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] prd_next_o,
  output logic             dir_up_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] prd_q, prd_d;
  logic             up_q, up_d;
  logic             at_zero, at_peak, dir_up;

  // next-state logic
  always_comb begin
    at_zero = (cnt_q == '0);
    at_peak = (cnt_q == prd_q);
    if (at_zero)            dir_up = 1'b1;
    else if (cnt_q >= prd_q) dir_up = 1'b0;
    else                    dir_up = up_q;
    up_d = dir_up;
    if (prd_q == '0)        cnt_d = '0;
    else if (dir_up)        cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q - 1'b1;
    prd_d = at_zero ? period_in : prd_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      prd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      prd_q <= prd_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign prd_o      = prd_q;
  assign prd_next_o = prd_d;
  assign dir_up_o   = dir_up;
  assign load_o     = at_zero | at_peak;

  // R1: the count stays within the active period
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_q != '0) |-> (cnt_q <= prd_q));
endmodule

// File: rtl/cpwm_frac_conv.sv
module cpwm_frac_conv #(
  parameter int STEP_W = 8
) (
  input  logic [STEP_W-1:0] frac_hi,
  input  logic [STEP_W-1:0] spc,
  input  logic              conv_en,
  output logic [STEP_W-1:0] steps
);
  localparam int            PW    = 2 * STEP_W;
  localparam logic [PW-1:0] ROUND = PW'(1) << (STEP_W - 1);

  logic [PW-1:0]     prod, rounded;
  logic [STEP_W-1:0] raw, limit;

  always_comb begin
    prod    = {{STEP_W{1'b0}}, frac_hi} * {{STEP_W{1'b0}}, spc};
    rounded = prod + ROUND;
    raw     = conv_en ? rounded[PW-1:STEP_W] : frac_hi;
    limit   = spc - 1'b1;
    if (spc == '0)       steps = '0;
    else if (raw > limit) steps = limit;
    else                 steps = raw;
  end
endmodule

// File: rtl/cpwm_edge_plan.sv
module cpwm_edge_plan
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 8
) (
  input  logic [CNT_W-1:0]  cmp_int,
  input  logic [CNT_W-1:0]  prd_next,
  input  logic [STEP_W-1:0] steps,
  input  logic [STEP_W-1:0] spc,
  input  edge_sel_e         mode,
  input  logic              sym_en,
  output logic [STEP_W-1:0] rise_f,
  output logic [STEP_W-1:0] fall_f,
  output logic              shift
);
  logic in_range;

  always_comb begin
    in_range = (cmp_int != '0) && (cmp_int < prd_next);
    rise_f   = '0;
    fall_f   = '0;
    shift    = 1'b0;
    if (in_range) begin
      unique case (mode)
        EDGE_NONE: ;
        EDGE_RISE: rise_f = steps;
        EDGE_FALL: fall_f = steps;
        EDGE_BOTH: begin
          if (sym_en) begin
            fall_f = steps;
            if (steps != '0) begin
              rise_f = spc - steps;
              shift  = 1'b1;
            end
          end else begin
            rise_f = steps;
            fall_f = steps;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage #(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  prd_act,
  input  logic              dir_up,
  input  logic [CNT_W-1:0]  cmp_new,
  input  logic [STEP_W-1:0] rise_new,
  input  logic [STEP_W-1:0] fall_new,
  input  logic              shift_new,
  output logic              pwm_o,
  output logic [STEP_W-1:0] rise_o,
  output logic [STEP_W-1:0] fall_o
);
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [STEP_W-1:0] rise_q, rise_d, fall_q, fall_d;
  logic              shift_q, shift_d;
  logic              pwm_q, pwm_d;
  logic              hold_hi, hold_lo;
  logic [CNT_W-1:0]  rise_pt;

  // next-state logic
  always_comb begin
    hold_hi = (cmp_q == '0);
    hold_lo = !hold_hi && (cmp_q >= prd_act);
    rise_pt = cmp_q + {{(CNT_W-1){1'b0}}, shift_q};
    pwm_d   = pwm_q;
    if (hold_hi)                         pwm_d = 1'b1;
    else if (hold_lo)                    pwm_d = 1'b0;
    else if (dir_up && (cnt == cmp_q))   pwm_d = 1'b0;
    else if (!dir_up && (cnt == rise_pt)) pwm_d = 1'b1;
    cmp_d   = load ? cmp_new   : cmp_q;
    rise_d  = load ? rise_new  : rise_q;
    fall_d  = load ? fall_new  : fall_q;
    shift_d = load ? shift_new : shift_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      shift_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      shift_q <= shift_d;
      pwm_q   <= pwm_d;
    end
  end

  assign pwm_o  = pwm_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R7: a zero compare keeps the output high
  assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q == '0) |=> pwm_q);
  // R7: a compare at or above the period keeps the output low
  assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_q != '0) && (cmp_q >= prd_act)) |=> !pwm_q);
  // R6: falling edges happen only on the up slope or under a low hold
  assert_fall_on_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_q) |-> ($past(dir_up) || $past(cmp_q >= prd_act)));
  // R6: rising edges happen only on the down slope or under a high hold
  assert_rise_on_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> ($past(!dir_up) || $past(cmp_q == '0)));
  // R10: a shifted rising edge always carries both fine offsets
  assert_sym_offsets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_q |-> ((rise_q != '0) && (fall_q != '0)));
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W+FRAC_W-1:0] cmp_word,
  input  logic [CNT_W-1:0]        period,
  input  logic [STEP_W-1:0]       steps_per_clk,
  input  logic [1:0]              edge_sel,
  input  logic                    sym_en,
  input  logic                    conv_en,
  output logic                    pwm_out,
  output logic [STEP_W-1:0]       rise_steps,
  output logic [STEP_W-1:0]       fall_steps
);
  localparam int WORD_W = CNT_W + FRAC_W;

  logic [CNT_W-1:0]  cnt, prd_act, prd_next, cmp_int;
  logic              dir_up, load;
  logic [STEP_W-1:0] frac_hi, conv_steps, rise_new, fall_new;
  logic              shift_new;
  logic              unused_frac_lo;

  assign cmp_int        = cmp_word[WORD_W-1:FRAC_W];
  assign frac_hi        = cmp_word[FRAC_W-1 -: STEP_W];
  assign unused_frac_lo = ^cmp_word[FRAC_W-STEP_W-1:0];

  cpwm_tri_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_in  (period),
    .cnt_o      (cnt),
    .prd_o      (prd_act),
    .prd_next_o (prd_next),
    .dir_up_o   (dir_up),
    .load_o     (load)
  );

  cpwm_frac_conv #(.STEP_W(STEP_W)) u_conv (
    .frac_hi (frac_hi),
    .spc     (steps_per_clk),
    .conv_en (conv_en),
    .steps   (conv_steps)
  );

  cpwm_edge_plan #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_plan (
    .cmp_int  (cmp_int),
    .prd_next (prd_next),
    .steps    (conv_steps),
    .spc      (steps_per_clk),
    .mode     (edge_sel_e'(edge_sel)),
    .sym_en   (sym_en),
    .rise_f   (rise_new),
    .fall_f   (fall_new),
    .shift    (shift_new)
  );

  cpwm_out_stage #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .cnt       (cnt),
    .prd_act   (prd_act),
    .dir_up    (dir_up),
    .cmp_new   (cmp_int),
    .rise_new  (rise_new),
    .fall_new  (fall_new),
    .shift_new (shift_new),
    .pwm_o     (pwm_out),
    .rise_o    (rise_steps),
    .fall_o    (fall_steps)
  );

  // R11: fine offsets change only after a turnaround load
  assert_fine_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(rise_steps) && $stable(fall_steps)));
  // R5: the converted step count never reaches steps-per-clock
  assert_step_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (steps_per_clk != '0) |-> (conv_steps < steps_per_clk));
endmodule

// File: tb/cpwm_top_tb.sv
module cpwm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmp_word = 32'h0008_0000;
  logic [15:0] period = 16'd20;
  logic [7:0]  steps_per_clk = 8'd100;
  logic [1:0]  edge_sel = 2'd2;
  logic        sym_en = 1'b0;
  logic        conv_en = 1'b1;
  logic        pwm_out;
  logic [7:0]  rise_steps, fall_steps;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  cpwm_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_word(cmp_word), .period(period),
    .steps_per_clk(steps_per_clk), .edge_sel(edge_sel), .sym_en(sym_en),
    .conv_en(conv_en), .pwm_out(pwm_out), .rise_steps(rise_steps),
    .fall_steps(fall_steps)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_up, m_prd, m_cmp, m_rf, m_ff, m_sh, m_pwm;
  int md, mn, mp, mf, ms;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_prd = 0; m_cmp = 0;
      m_rf = 0; m_ff = 0; m_sh = 0; m_pwm = 0;
    end else begin
      if (m_cnt == 0) md = 1; else if (m_cnt >= m_prd) md = 0; else md = m_up;
      if (m_cmp == 0) m_pwm = 1;
      else if (m_cmp >= m_prd) m_pwm = 0;
      else if (md == 1 && m_cnt == m_cmp) m_pwm = 0;
      else if (md == 0 && m_cnt == m_cmp + m_sh) m_pwm = 1;
      mn = (m_prd == 0) ? 0 : (md == 1 ? m_cnt + 1 : m_cnt - 1);
      if (m_cnt == 0 || m_cnt == m_prd) begin
        mp = (m_cnt == 0) ? int'(period) : m_prd;
        m_cmp = int'(cmp_word[31:16]);
        mf = int'(cmp_word[15:8]);
        ms = conv_en ? (mf * int'(steps_per_clk) + 128) / 256 : mf;
        if (steps_per_clk == 0) ms = 0;
        else if (ms > int'(steps_per_clk) - 1) ms = int'(steps_per_clk) - 1;
        m_rf = 0; m_ff = 0; m_sh = 0;
        if (m_cmp != 0 && m_cmp < mp) begin
          case (edge_sel)
            2'd1: m_rf = ms;
            2'd2: m_ff = ms;
            2'd3: if (sym_en) begin
                    m_ff = ms;
                    if (ms != 0) begin m_rf = int'(steps_per_clk) - ms; m_sh = 1; end
                  end else begin m_rf = ms; m_ff = ms; end
            default: ;
          endcase
        end
        m_prd = mp;
      end
      m_cnt = mn; m_up = md;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 pwm vs model", int'(pwm_out), m_pwm);
      chk("R11 rise vs model", int'(rise_steps), m_rf);
      chk("R11 fall vs model", int'(fall_steps), m_ff);
    end
  end

  task automatic setup(logic [31:0] w, logic [7:0] s, logic [1:0] e, logic sy, logic cv);
    @(negedge clk);
    cmp_word = w; steps_per_clk = s; edge_sel = e; sym_en = sy; conv_en = cv;
    repeat (45) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    logic p;
    p = pwm_out;
    @(negedge clk);
    while (!(p == 1'b0 && pwm_out == 1'b1)) begin p = pwm_out; @(negedge clk); end
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pwm_out) begin lo++; @(negedge clk); end
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_out) highs++; end
  endtask

  initial begin
    int hi, lo, h;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 pwm in reset", int'(pwm_out), 0);
    chk("R12 rise in reset", int'(rise_steps), 0);
    chk("R12 fall in reset", int'(fall_steps), 0);
    rst_n = 1'b1;

    // R1, R6: integer compare only
    setup(32'h0008_0000, 8'd100, 2'd2, 1'b0, 1'b1);
    measure(hi, lo);
    chk("R6 high clocks", hi, 16);
    chk("R1 carrier cycle", hi + lo, 40);

    // R2, R3, R8: half fraction on falling edge
    setup(32'h0008_8000, 8'd100, 2'd2, 1'b0, 1'b1);
    chk("R3 fall converted", int'(fall_steps), 50);
    chk("R8 rise idle in fall mode", int'(rise_steps), 0);
    measure(hi, lo);
    chk("R2 integer part sets high time", hi, 16);

    // R8: rising edge only
    setup(32'h0008_8000, 8'd100, 2'd1, 1'b0, 1'b1);
    chk("R8 rise converted", int'(rise_steps), 50);
    chk("R8 fall idle in rise mode", int'(fall_steps), 0);

    // R4: conversion off
    setup(32'h0008_3700, 8'd100, 2'd2, 1'b0, 1'b0);
    chk("R4 raw fraction", int'(fall_steps), 55);

    // R5: clamps
    setup(32'h0008_C800, 8'd100, 2'd2, 1'b0, 1'b0);
    chk("R5 raw clamp", int'(fall_steps), 99);
    setup(32'h0008_FF00, 8'd63, 2'd2, 1'b0, 1'b1);
    chk("R5 converted clamp", int'(fall_steps), 62);
    setup(32'h0008_8000, 8'd0, 2'd2, 1'b0, 1'b1);
    chk("R5 zero steps per clock", int'(fall_steps), 0);

    // R9: both edges, not symmetric
    setup(32'h0008_4000, 8'd100, 2'd3, 1'b0, 1'b1);
    chk("R9 rise", int'(rise_steps), 25);
    chk("R9 fall", int'(fall_steps), 25);
    measure(hi, lo);
    chk("R9 high clocks", hi, 16);

    // R10: symmetric
    setup(32'h0008_4000, 8'd100, 2'd3, 1'b1, 1'b1);
    chk("R10 fall", int'(fall_steps), 25);
    chk("R10 rise complement", int'(rise_steps), 75);
    measure(hi, lo);
    chk("R10 high clocks shifted", hi, 17);
    setup(32'h0008_0000, 8'd100, 2'd3, 1'b1, 1'b1);
    chk("R10 zero fraction rise", int'(rise_steps), 0);
    measure(hi, lo);
    chk("R10 zero fraction high clocks", hi, 16);

    // R7: holds
    setup(32'h0000_8000, 8'd100, 2'd3, 1'b0, 1'b1);
    count_high(45, h);
    chk("R7 zero compare high", h, 45);
    chk("R7 zero compare fine", int'(fall_steps), 0);
    setup(32'h0019_8000, 8'd100, 2'd3, 1'b0, 1'b1);
    count_high(45, h);
    chk("R7 above period low", h, 0);
    chk("R7 above period fine", int'(rise_steps), 0);
    setup(32'h0014_0000, 8'd100, 2'd2, 1'b0, 1'b1);
    count_high(45, h);
    chk("R7 equal period low", h, 0);

    // R11: mid-cycle change is held until the turnaround
    setup(32'h0008_4000, 8'd100, 2'd3, 1'b1, 1'b1);
    while (!(m_cnt == 5 && m_up == 1)) @(negedge clk);
    cmp_word = 32'h000A_C000;
    repeat (3) @(negedge clk);
    chk("R11 fall held", int'(fall_steps), 25);
    chk("R11 rise held", int'(rise_steps), 75);
    while (m_cnt != m_prd) @(negedge clk);
    chk("R11 still held at peak", int'(fall_steps), 25);
    @(negedge clk);
    chk("R11 fall after peak load", int'(fall_steps), 75);
    chk("R11 rise after peak load", int'(rise_steps), 25);

    // R1: period change adopted at zero
    @(negedge clk);
    period = 16'd30;
    cmp_word = 32'h0008_0000;
    repeat (70) @(negedge clk);
    measure(hi, lo);
    chk("R1 new carrier cycle", hi + lo, 60);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule